// File: doc/BRIEF.md
# Configuration Retry Handler for a PCIe Root Port

This block sits in a PCIe root port, between a host-side port that issues configuration accesses and the downstream request/completion path. The host presents one configuration read or write at a time. Each access carries a bus, device, function, byte offset, access size and, for writes, right-justified data. Accesses to bus 0 are served from a small configuration space inside the root. All other accesses go downstream as Type 1 requests. The block then waits for the completion and returns read data right-justified and masked to the requested size.

A downstream device may answer with Configuration Request Retry Status. In that case the block issues the same request again, bit for bit, after a fixed gap. If the device keeps answering with retry past a timeout, the block reports device-not-found. Software visibility is an exception. If it is enabled and a read of offset 0 gets a retry answer, the block does not issue it again. It returns the special Vendor ID value instead, and that response carries no retry indication. Every other read, and every write, is still issued again. The gap and the timeout are parameters counted in clock cycles. The defaults are one microsecond and 500 ms at 125 MHz.

Top module: `cfg_retry_engine`

## Requirements
- R1: Accesses with bus number 0 are never sent downstream. They use a local space of ROOT_DWORDS dwords indexed by offset[11:2]. Dword 0 always reads ROOT_ID and ignores writes. The other dwords are writable per byte lane and reset to zero. Indices at or beyond ROOT_DWORDS read zero.
- R2: A downstream request carries ds_req_addr = {4'b0, bus[7:0], dev[4:0], fn[2:0], offset[11:2], 2'b01}, where 2'b01 marks a Type 1 request. Byte enables depend on the size and a = offset[1:0]: size 1 gives 4'b0001<<a, size 2 gives 4'b0011<<a, any other size gives 4'b1111. The write data is shifted left by 8*a for sizes 1 and 2 and is not shifted otherwise.
- R3: A completion status of 3'b010 means retry. Any other status ends the request, and that status is passed to host_rsp_status together with the completion data.
- R4: With software visibility off, a retry completion makes the block issue a request identical to the first one. ds_req_valid rises RETRY_GAP_CYC clock edges after the edge that took in the retry completion.
- R5: The visibility enable is sampled when the request is accepted. If it is set and a read of dword index 0 gets a retry, nothing is issued again. The response is 32'hFFFF0001 aligned per R8, with status 0 and host_rsp_crs low.
- R6: With visibility enabled, reads of other offsets and all writes that get a retry are still issued again.
- R7: If a retry completion arrives when at least TIMEOUT_CYC cycles have passed since acceptance, the request ends. host_rsp_dnf and host_rsp_crs are high in the same cycle as host_rsp_valid, the status is 3'b010, and the read data is all ones aligned per R8. The elapsed count restarts for each new request.
- R8: For size 1 or 2, the read data is the completion dword shifted right by 8*offset[1:0], then masked to 8 or 16 bits. Other sizes return the whole dword. Writes always return zero data.
- R9: Only one request is outstanding. host_req_ready is high only when idle, and a downstream request is held stable while ds_req_ready is low. host_rsp_valid is a one-cycle pulse.
- R10: After reset, host_req_ready is 1 while host_rsp_valid and ds_req_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_vis_en | input | 1 | Software visibility enable, sampled on acceptance |
| host_req_valid | input | 1 | Host access request |
| host_req_ready | output | 1 | Block idle, request accepted this cycle |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_bus | input | 8 | Bus number |
| host_req_dev | input | 5 | Device number |
| host_req_fn | input | 3 | Function number |
| host_req_off | input | 12 | Register byte offset |
| host_req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| host_req_wdata | input | 32 | Right-justified write data |
| host_rsp_valid | output | 1 | Response pulse |
| host_rsp_rdata | output | 32 | Aligned read data |
| host_rsp_status | output | 3 | Final completion status |
| host_rsp_dnf | output | 1 | Device not found after retry timeout |
| host_rsp_crs | output | 1 | Request ended with retry status |
| ds_req_valid | output | 1 | Downstream request valid |
| ds_req_ready | input | 1 | Downstream request taken |
| ds_req_write | output | 1 | Downstream write |
| ds_req_addr | output | 32 | Type 1 address word |
| ds_req_be | output | 4 | Byte enables |
| ds_req_wdata | output | 32 | Lane-placed write data |
| ds_cpl_valid | input | 1 | Completion valid |
| ds_cpl_status | input | 3 | Completion status |
| ds_cpl_data | input | 32 | Completion dword |

## Verification
The hardest case to reach is the retry timeout. The device must keep answering with retry through many gap-and-issue rounds until the elapsed count passes its limit. The next request must then show that the count was cleared. The bench shrinks the gap to 8 cycles and the timeout to 300 cycles. It uses a scripted downstream model that answers a set number of retries before a real completion, with a near-endless count for the timeout case. The same model times each re-issue edge against the retry completion and compares every re-issued request with the expected fields. It also stalls the request handshake on alternate cycles, which exercises the hold-stable rule.

// File: rtl/cfg_retry_pkg.sv
// Shared types and helpers for the configuration retry handler.
// Assumes 32-bit dword data paths and 12-bit configuration offsets.
package cfg_retry_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOCAL,
        ST_ISSUE,
        ST_WAIT,
        ST_GAP
    } rty_state_t;

    localparam logic [2:0]  CPL_RETRY = 3'b010;
    localparam logic [31:0] VIS_WORD  = 32'hFFFF_0001;

    typedef struct packed {
        logic        write;
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  fn;
        logic [11:0] off;
        logic [2:0]  size;
        logic [31:0] wdata;
    } cfg_req_t;

    // Lane offset used for shifting: only sub-dword sizes are shifted.
    function automatic logic [1:0] lane_shift(input logic [2:0] size, input logic [1:0] a);
        return (size == 3'd1 || size == 3'd2) ? a : 2'd0;
    endfunction

    // Byte enables for a given size and low address bits.
    function automatic logic [3:0] lane_mask(input logic [2:0] size, input logic [1:0] a);
        case (size)
            3'd1:    return 4'b0001 << a;
            3'd2:    return 4'b0011 << a;
            default: return 4'b1111;
        endcase
    endfunction

    // Right-justify and mask a completion dword to the access size.
    function automatic logic [31:0] align_rd(input logic [31:0] dw, input logic [2:0] size,
                                             input logic [1:0] a);
        logic [31:0] sh;
        sh = dw >> {lane_shift(size, a), 3'b000};
        case (size)
            3'd1:    return sh & 32'h0000_00FF;
            3'd2:    return sh & 32'h0000_FFFF;
            default: return sh;
        endcase
    endfunction

endpackage

// File: rtl/cfg_retry_root_space.sv
// Root-local configuration space for bus 0 accesses.
// Dword 0 holds a fixed identifier and is read-only; the rest are
// byte-writable. Out-of-range indices read zero and ignore writes.
module cfg_retry_root_space #(
    parameter int          ROOT_DWORDS = 16,
    parameter logic [31:0] ROOT_ID     = 32'h7A51_1D0E
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [9:0]  idx,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);
    localparam int IDXW = (ROOT_DWORDS > 1) ? $clog2(ROOT_DWORDS) : 1;

    logic [31:0] regs [ROOT_DWORDS];
    logic        hit;

    assign hit = (idx < 10'(ROOT_DWORDS));

    // Register array: reset to ID/zero, byte-lane writes except dword 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROOT_DWORDS; i++)
                regs[i] <= (i == 0) ? ROOT_ID : 32'h0;
        end else if (wr_en && hit && (idx != 10'd0)) begin
            for (int b = 0; b < 4; b++)
                if (be[b]) regs[idx[IDXW-1:0]][8*b +: 8] <= wdata[8*b +: 8];
        end
    end

    // Read port: combinational lookup with out-of-range zero.
    always_comb begin
        rdata = hit ? regs[idx[IDXW-1:0]] : 32'h0;
    end

endmodule

// File: rtl/cfg_retry_timer.sv
// Gap and timeout counters for the retry handler.
// elapsed counts cycles since the last restart and saturates at the
// timeout; the gap counter runs only while gap_run is high.
module cfg_retry_timer #(
    parameter int GAP_CYC     = 125,
    parameter int TIMEOUT_CYC = 62_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic gap_run,
    output logic gap_done,
    output logic expired
);
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    logic [GW-1:0] gap_cnt;
    logic [TW-1:0] elapsed;

    // Elapsed-time counter since request acceptance, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            elapsed <= '0;
        else if (!expired)
            elapsed <= elapsed + TW'(1);
    end

    // Gap counter: cleared whenever the gap phase is not active.
    always_ff @(posedge clk) begin
        if (!rst_n || !gap_run)
            gap_cnt <= '0;
        else
            gap_cnt <= gap_cnt + GW'(1);
    end

    assign expired  = (elapsed == TW'(TIMEOUT_CYC));
    assign gap_done = gap_run && (gap_cnt == GW'(GAP_CYC - 1));

endmodule

// File: rtl/cfg_retry_engine.sv
// Configuration retry handler top. Accepts one host configuration access
// at a time, serves bus 0 locally, sends others downstream as Type 1
// requests, re-issues on retry completions after a gap, applies the
// software-visibility rule for offset-0 reads, and times out to
// device-not-found. Assumes RETRY_GAP_CYC >= 1.
module cfg_retry_engine
    import cfg_retry_pkg::*;
#(
    parameter int          RETRY_GAP_CYC = 125,
    parameter int          TIMEOUT_CYC   = 62_500_000,
    parameter int          ROOT_DWORDS   = 16,
    parameter logic [31:0] ROOT_ID       = 32'h7A51_1D0E
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_vis_en,
    input  logic        host_req_valid,
    output logic        host_req_ready,
    input  logic        host_req_write,
    input  logic [7:0]  host_req_bus,
    input  logic [4:0]  host_req_dev,
    input  logic [2:0]  host_req_fn,
    input  logic [11:0] host_req_off,
    input  logic [2:0]  host_req_size,
    input  logic [31:0] host_req_wdata,
    output logic        host_rsp_valid,
    output logic [31:0] host_rsp_rdata,
    output logic [2:0]  host_rsp_status,
    output logic        host_rsp_dnf,
    output logic        host_rsp_crs,
    output logic        ds_req_valid,
    input  logic        ds_req_ready,
    output logic        ds_req_write,
    output logic [31:0] ds_req_addr,
    output logic [3:0]  ds_req_be,
    output logic [31:0] ds_req_wdata,
    input  logic        ds_cpl_valid,
    input  logic [2:0]  ds_cpl_status,
    input  logic [31:0] ds_cpl_data
);
    rty_state_t  state;
    cfg_req_t    req_q;
    logic        vis_q;
    logic        accept;
    logic        gap_done;
    logic        expired;
    logic [31:0] root_rdata;
    logic [31:0] lane_wdata;
    logic [3:0]  lane_be;
    logic        vis_hit;

    assign accept         = host_req_valid && host_req_ready;
    assign host_req_ready = (state == ST_IDLE);
    assign lane_be        = lane_mask(req_q.size, req_q.off[1:0]);
    assign lane_wdata     = req_q.wdata << {lane_shift(req_q.size, req_q.off[1:0]), 3'b000};
    assign vis_hit        = vis_q && !req_q.write && (req_q.off[11:2] == 10'd0);

    assign ds_req_valid = (state == ST_ISSUE);
    assign ds_req_write = req_q.write;
    assign ds_req_addr  = {4'h0, req_q.bus, req_q.dev, req_q.fn, req_q.off[11:2], 2'b01};
    assign ds_req_be    = lane_be;
    assign ds_req_wdata = lane_wdata;

    cfg_retry_timer #(
        .GAP_CYC     (RETRY_GAP_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (accept),
        .gap_run  (state == ST_GAP),
        .gap_done (gap_done),
        .expired  (expired)
    );

    cfg_retry_root_space #(
        .ROOT_DWORDS (ROOT_DWORDS),
        .ROOT_ID     (ROOT_ID)
    ) u_root (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en ((state == ST_LOCAL) && req_q.write),
        .idx   (req_q.off[11:2]),
        .be    (lane_be),
        .wdata (lane_wdata),
        .rdata (root_rdata)
    );

    // Request sequencing, retry decisions and response generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state           <= ST_IDLE;
            req_q           <= '0;
            vis_q           <= 1'b0;
            host_rsp_valid  <= 1'b0;
            host_rsp_rdata  <= '0;
            host_rsp_status <= '0;
            host_rsp_dnf    <= 1'b0;
            host_rsp_crs    <= 1'b0;
        end else begin
            host_rsp_valid <= 1'b0;
            host_rsp_dnf   <= 1'b0;
            host_rsp_crs   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        req_q.write <= host_req_write;
                        req_q.bus   <= host_req_bus;
                        req_q.dev   <= host_req_dev;
                        req_q.fn    <= host_req_fn;
                        req_q.off   <= host_req_off;
                        req_q.size  <= host_req_size;
                        req_q.wdata <= host_req_wdata;
                        vis_q       <= sw_vis_en;
                        state       <= (host_req_bus == 8'd0) ? ST_LOCAL : ST_ISSUE;
                    end
                end
                ST_LOCAL: begin
                    host_rsp_valid  <= 1'b1;
                    host_rsp_status <= 3'd0;
                    host_rsp_rdata  <= req_q.write ? 32'h0
                                     : align_rd(root_rdata, req_q.size, req_q.off[1:0]);
                    state           <= ST_IDLE;
                end
                ST_ISSUE: begin
                    if (ds_req_ready) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (ds_cpl_valid) begin
                        if (ds_cpl_status != CPL_RETRY) begin
                            host_rsp_valid  <= 1'b1;
                            host_rsp_status <= ds_cpl_status;
                            host_rsp_rdata  <= req_q.write ? 32'h0
                                             : align_rd(ds_cpl_data, req_q.size, req_q.off[1:0]);
                            state           <= ST_IDLE;
                        end else if (vis_hit) begin
                            host_rsp_valid  <= 1'b1;
                            host_rsp_status <= 3'd0;
                            host_rsp_rdata  <= align_rd(VIS_WORD, req_q.size, req_q.off[1:0]);
                            state           <= ST_IDLE;
                        end else if (expired) begin
                            host_rsp_valid  <= 1'b1;
                            host_rsp_status <= CPL_RETRY;
                            host_rsp_dnf    <= 1'b1;
                            host_rsp_crs    <= 1'b1;
                            host_rsp_rdata  <= req_q.write ? 32'h0
                                             : align_rd(32'hFFFF_FFFF, req_q.size, req_q.off[1:0]);
                            state           <= ST_IDLE;
                        end else begin
                            state <= ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_done) state <= ST_ISSUE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfg_retry_engine_chk.sv
// Property checker for cfg_retry_engine, attached by bind. Observes the
// top-level ports only.
module cfg_retry_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_req_ready,
    input logic        host_rsp_valid,
    input logic [2:0]  host_rsp_status,
    input logic        host_rsp_dnf,
    input logic        host_rsp_crs,
    input logic        ds_req_valid,
    input logic        ds_req_ready,
    input logic        ds_req_write,
    input logic [31:0] ds_req_addr,
    input logic [3:0]  ds_req_be,
    input logic [31:0] ds_req_wdata
);
    // R9: a stalled downstream request stays valid and unchanged.
    a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        ds_req_valid && !ds_req_ready |=> ds_req_valid && $stable(ds_req_addr)
            && $stable(ds_req_be) && $stable(ds_req_wdata) && $stable(ds_req_write));

    // R9: never accepting a host request while a downstream one is pending.
    a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_req_ready && ds_req_valid));

    // R9: responses are single-cycle pulses.
    a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        host_rsp_valid |=> !host_rsp_valid);

    // R1: bus 0 never appears downstream.
    a_r1_no_bus0_downstream: assert property (@(posedge clk) disable iff (!rst_n)
        ds_req_valid |-> ds_req_addr[27:20] != 8'h00);

    // R2: Type 1 marker and zero top nibble on every downstream request.
    a_r2_type1_format: assert property (@(posedge clk) disable iff (!rst_n)
        ds_req_valid |-> ds_req_addr[1:0] == 2'b01 && ds_req_addr[31:28] == 4'h0);

    // R7: retry indication only together with acknowledge and not-found.
    a_r7_crs_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        host_rsp_crs |-> host_rsp_valid && host_rsp_dnf && host_rsp_status == 3'b010);

    // R5: a response never carries retry status without the indication.
    a_r5_no_silent_retry: assert property (@(posedge clk) disable iff (!rst_n)
        host_rsp_valid && host_rsp_status == 3'b010 |-> host_rsp_crs);

endmodule

bind cfg_retry_engine cfg_retry_engine_chk u_chk (.*);

// File: tb/cfg_retry_engine_test.sv
// Scoreboard bench: a driver task queues expected responses, a monitor
// compares them, and a scripted downstream model answers with retries.
module cfg_retry_engine_test;
    localparam int          GAP = 8;
    localparam int          TMO = 300;
    localparam logic [31:0] RID = 32'h7A51_1D0E;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sw_vis_en;
    logic        host_req_valid;
    logic        host_req_ready;
    logic        host_req_write;
    logic [7:0]  host_req_bus;
    logic [4:0]  host_req_dev;
    logic [2:0]  host_req_fn;
    logic [11:0] host_req_off;
    logic [2:0]  host_req_size;
    logic [31:0] host_req_wdata;
    logic        host_rsp_valid;
    logic [31:0] host_rsp_rdata;
    logic [2:0]  host_rsp_status;
    logic        host_rsp_dnf;
    logic        host_rsp_crs;
    logic        ds_req_valid;
    logic        ds_req_ready;
    logic        ds_req_write;
    logic [31:0] ds_req_addr;
    logic [3:0]  ds_req_be;
    logic [31:0] ds_req_wdata;
    logic        ds_cpl_valid;
    logic [2:0]  ds_cpl_status;
    logic [31:0] ds_cpl_data;

    always #4 clk = ~clk;

    cfg_retry_engine #(
        .RETRY_GAP_CYC (GAP),
        .TIMEOUT_CYC   (TMO),
        .ROOT_DWORDS   (16),
        .ROOT_ID       (RID)
    ) uut (.*);

    typedef struct {
        logic [31:0] rdata;
        logic [2:0]  status;
        logic        dnf;
        logic        crs;
        int          issues;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    int          n_vec = 0;
    int          n_bad = 0;
    int          cyc = 0;
    int          issue_cnt = 0;
    int          crs_left = 0;
    logic [2:0]  dev_status = 3'd0;
    bit          stall = 1'b0;
    bit          gap_pending = 1'b0;
    int          crs_cyc = 0;
    logic [31:0] x_addr, x_wdata;
    logic [3:0]  x_be;
    logic        x_write;
    logic [31:0] root_shadow [16];

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] dev_word(input logic [31:0] a);
        return a ^ 32'h5A3C_9617;
    endfunction

    function automatic logic [31:0] fit(input logic [31:0] dw, input logic [2:0] sz, input logic [1:0] a);
        if (sz == 3'd1) return (dw >> (8 * a)) & 32'hFF;
        if (sz == 3'd2) return (dw >> (8 * a)) & 32'hFFFF;
        return dw;
    endfunction

    // Driver: compute the expected response, queue it, present the request.
    task automatic do_req(input bit w, input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                          input logic [11:0] o, input logic [2:0] sz, input logic [31:0] wd,
                          input bit vis, input int crs_n, input logic [2:0] dst, input string tag);
        exp_t e;
        logic [1:0] a, sh;
        int idx;
        a   = o[1:0];
        sh  = (sz == 3'd1 || sz == 3'd2) ? a : 2'd0;
        idx = int'(o[11:2]);
        x_addr  = {4'h0, b, d, f, o[11:2], 2'b01};
        x_be    = (sz == 3'd1) ? (4'b0001 << a) : (sz == 3'd2) ? (4'b0011 << a) : 4'hF;
        x_wdata = wd << (8 * sh);
        x_write = w;
        e.tag = tag; e.dnf = 1'b0; e.crs = 1'b0; e.status = 3'd0;
        if (b == 8'd0) begin
            e.issues = 0;
            e.rdata  = w ? 32'h0 : fit((idx < 16) ? root_shadow[idx] : 32'h0, sz, a);
            if (w && idx != 0 && idx < 16)
                for (int k = 0; k < 4; k++)
                    if (x_be[k]) root_shadow[idx][8*k +: 8] = x_wdata[8*k +: 8];
        end else if (crs_n > 0 && vis && !w && idx == 0) begin
            e.issues = 1;
            e.rdata  = fit(32'hFFFF_0001, sz, a);
        end else if (crs_n >= 1000) begin
            e.issues = -2; e.status = 3'b010; e.dnf = 1'b1; e.crs = 1'b1;
            e.rdata  = w ? 32'h0 : fit(32'hFFFF_FFFF, sz, a);
        end else begin
            e.issues = crs_n + 1; e.status = dst;
            e.rdata  = w ? 32'h0 : fit(dev_word(x_addr), sz, a);
        end
        @(negedge clk);
        issue_cnt = 0; crs_left = crs_n; dev_status = dst; gap_pending = 1'b0;
        exp_q.push_back(e);
        host_req_write = w; host_req_bus = b; host_req_dev = d; host_req_fn = f;
        host_req_off = o; host_req_size = sz; host_req_wdata = wd; sw_vis_en = vis;
        host_req_valid = 1'b1;
        while (!host_req_ready) @(negedge clk);
        @(negedge clk);
        host_req_valid = 1'b0;
        chk({tag, " R9 ready low while busy"}, 32'(host_req_ready), 32'h0);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Downstream device model: scripted retries, request comparison, gap timing.
    initial begin
        bit prev_v = 1'b0;
        int dly = 0;
        ds_req_ready = 1'b0; ds_cpl_valid = 1'b0; ds_cpl_status = 3'd0; ds_cpl_data = 32'h0;
        forever begin
            @(negedge clk);
            cyc++;
            ds_cpl_valid = 1'b0;
            if (dly > 0) begin
                dly--;
                if (dly == 0) begin
                    ds_cpl_valid = 1'b1;
                    ds_cpl_data  = dev_word(x_addr);
                    if (crs_left > 0) begin
                        crs_left--; ds_cpl_status = 3'b010; crs_cyc = cyc; gap_pending = 1'b1;
                    end else
                        ds_cpl_status = dev_status;
                end
            end
            ds_req_ready = stall ? ~ds_req_ready : 1'b1;
            if (ds_req_valid && !prev_v && gap_pending) begin
                chk("R4 re-issue gap", 32'(cyc - crs_cyc), 32'(GAP + 1));
                gap_pending = 1'b0;
            end
            prev_v = ds_req_valid;
            if (rst_n && ds_req_valid && ds_req_ready) begin
                issue_cnt++;
                chk("R2 downstream address", ds_req_addr, x_addr);
                chk("R2 byte enables", 32'(ds_req_be), 32'(x_be));
                if (x_write) chk("R2 write data lanes", ds_req_wdata, x_wdata);
                chk("R4 write flag", 32'(ds_req_write), 32'(x_write));
                dly = 3;
            end
        end
    end

    // Monitor: pop expected items as responses appear.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && host_rsp_valid) begin
                if (exp_q.size() == 0) chk("R9 unexpected response", 32'h1, 32'h0);
                else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk({e.tag, " R8 data"}, host_rsp_rdata, e.rdata);
                    chk({e.tag, " R3 status"}, 32'(host_rsp_status), 32'(e.status));
                    chk({e.tag, " R7 not-found"}, 32'(host_rsp_dnf), 32'(e.dnf));
                    chk({e.tag, " R7 retry flag"}, 32'(host_rsp_crs), 32'(e.crs));
                    if (e.issues >= 0) chk({e.tag, " R4 issue count"}, 32'(issue_cnt), 32'(e.issues));
                    else chk({e.tag, " R7 several issues"}, 32'(issue_cnt > 1), 32'h1);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) root_shadow[i] = (i == 0) ? RID : 32'h0;
        rst_n = 1'b0; sw_vis_en = 1'b0; host_req_valid = 1'b0; host_req_write = 1'b0;
        host_req_bus = 8'h0; host_req_dev = 5'h0; host_req_fn = 3'h0; host_req_off = 12'h0;
        host_req_size = 3'd4; host_req_wdata = 32'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 ready after reset", 32'(host_req_ready), 32'h1);
        chk("R10 no response after reset", 32'(host_rsp_valid), 32'h0);
        chk("R10 no downstream after reset", 32'(ds_req_valid), 32'h0);

        // R1: root-local space
        do_req(1, 8'd0, 5'd0, 3'd0, 12'h008, 3'd4, 32'h1122_3344, 0, 0, 3'd0, "R1 local write");
        do_req(0, 8'd0, 5'd0, 3'd0, 12'h008, 3'd4, 32'h0, 0, 0, 3'd0, "R1 local readback");
        do_req(0, 8'd0, 5'd0, 3'd0, 12'h000, 3'd4, 32'h0, 0, 0, 3'd0, "R1 local id");
        do_req(1, 8'd0, 5'd0, 3'd0, 12'h009, 3'd1, 32'h0000_00AB, 0, 0, 3'd0, "R1 local byte write");
        do_req(0, 8'd0, 5'd0, 3'd0, 12'h008, 3'd4, 32'h0, 0, 0, 3'd0, "R1 byte merge");
        do_req(0, 8'd0, 5'd0, 3'd0, 12'h00A, 3'd2, 32'h0, 0, 0, 3'd0, "R1 local half read");
        do_req(1, 8'd0, 5'd0, 3'd0, 12'h000, 3'd4, 32'hDEAD_BEEF, 0, 0, 3'd0, "R1 id write ignored");
        do_req(0, 8'd0, 5'd0, 3'd0, 12'h000, 3'd4, 32'h0, 0, 0, 3'd0, "R1 id unchanged");
        do_req(0, 8'd0, 5'd0, 3'd0, 12'h100, 3'd4, 32'h0, 0, 0, 3'd0, "R1 out of range");
        // R3: plain completions
        do_req(0, 8'd3, 5'd5, 3'd2, 12'h010, 3'd4, 32'h0, 0, 0, 3'd0, "R3 plain read");
        do_req(0, 8'd3, 5'd5, 3'd2, 12'h010, 3'd4, 32'h0, 0, 0, 3'd1, "R3 other status");
        // R4: retries with visibility off
        do_req(0, 8'd7, 5'd1, 3'd0, 12'h000, 3'd4, 32'h0, 0, 2, 3'd0, "R4 read retried");
        do_req(1, 8'd7, 5'd1, 3'd0, 12'h016, 3'd2, 32'h0000_BEEF, 0, 1, 3'd0, "R4 write retried");
        // R5: visibility synthesis
        do_req(0, 8'd9, 5'd2, 3'd1, 12'h000, 3'd4, 32'h0, 1, 1, 3'd0, "R5 vis dword");
        do_req(0, 8'd9, 5'd2, 3'd1, 12'h000, 3'd2, 32'h0, 1, 1, 3'd0, "R5 vis vendor");
        do_req(0, 8'd9, 5'd2, 3'd1, 12'h002, 3'd2, 32'h0, 1, 1, 3'd0, "R5 vis upper");
        do_req(0, 8'd9, 5'd2, 3'd1, 12'h001, 3'd1, 32'h0, 1, 1, 3'd0, "R5 vis byte1");
        // R6: visibility on, still retried
        do_req(0, 8'd9, 5'd2, 3'd1, 12'h004, 3'd4, 32'h0, 1, 2, 3'd0, "R6 vis other read");
        do_req(1, 8'd9, 5'd2, 3'd1, 12'h000, 3'd4, 32'hCAFE_0123, 1, 1, 3'd0, "R6 vis write");
        // R8: sub-dword alignment
        do_req(0, 8'd4, 5'd3, 3'd7, 12'h023, 3'd1, 32'h0, 0, 0, 3'd0, "R8 byte3");
        do_req(0, 8'd4, 5'd3, 3'd7, 12'h022, 3'd2, 32'h0, 0, 0, 3'd0, "R8 half2");
        // R9: downstream stall
        stall = 1'b1;
        do_req(0, 8'd5, 5'd8, 3'd3, 12'h040, 3'd4, 32'h0, 0, 1, 3'd0, "R9 stalled");
        stall = 1'b0;
        // R7: timeout then fresh request
        do_req(0, 8'd6, 5'd4, 3'd0, 12'h000, 3'd4, 32'h0, 0, 100000, 3'd0, "R7 timeout read");
        do_req(0, 8'd6, 5'd4, 3'd0, 12'h008, 3'd4, 32'h0, 0, 3, 3'd0, "R7 count restarted");

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule